// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns a stream of single-cycle input enables, nominally 262144 per second, into a one-cycle tick once per second. The timebase feeding it is trimmed on purpose to run slightly fast. Each second, the block discards a programmable number of input enables so that the binary divider behind it sees exactly 2^DIV_BITS counted enables per second. Correction only ever removes enables and never adds them.

The withheld enables are not removed in one burst. One enable is withheld every 2^G enables from the start of the second, with G = DIV_BITS - CAL_W, until the programmed count has been removed. The calibration value is captured at reset and at each second boundary. The block also provides the upper bits of the sub-second phase and a set of single-cycle strobes at 2, 4, 8, ... per second. Switch debounce and colon blinking can use these. All pins are plain control and status signals, so there is no handshake and no back-pressure.

Top module: `cal_prescaler`

## Requirements
- R1: Only clock cycles with `pulse_en_i` high advance the prescaler. With a calibration value of 0, `tick_1hz_o` fires once per 2^DIV_BITS enables.
- R2: `tick_1hz_o` is high for exactly one clock cycle. It rises in the cycle after the edge that samples the enable completing the second, and it never follows a cycle without an enable.
- R3: With calibration value n (unsigned, 0 to 2^CAL_W-1), each second spans exactly 2^DIV_BITS + n enables, and exactly n of them are withheld from the divider.
- R4: Counting enables from 1 within a second, the enables numbered i*2^G for i = 1..n are the withheld ones, and the phase does not advance on them. As a result, the phase MSB rises on the enable number r at which r - min(n, floor(r/2^G)) first equals 2^(DIV_BITS-1).
- R5: A cycle without an enable changes neither the phase nor the tick. The tick stays low in the following cycle.
- R6: `phase_o` holds the top TAP_W bits of the number of counted enables in the current second. It reads 0 in the tick cycle. With n = 0 and an enable every cycle, its MSB is high for 2^(DIV_BITS-1) cycles per second.
- R7: `tap_stb_o[j]` pulses for one cycle 2^(j+1) times per second. The last of these pulses coincides with the tick.
- R8: `cal_n_i` is sampled while reset is held and at each second boundary. A change in the middle of a second first applies to the following second.
- R9: While `rst_ni` is low (synchronous, active low), the tick, phase and strobes read 0. The first second after release is a full second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pulse_en_i | input | 1 | Timebase enable, one cycle per input pulse |
| cal_n_i | input | CAL_W | Enables withheld per second |
| tick_1hz_o | output | 1 | One-cycle pulse per second |
| phase_o | output | TAP_W | Upper bits of the sub-second count |
| tap_stb_o | output | TAP_W | Strobes at 2^(j+1) per second |

## Verification
The bench builds the block with DIV_BITS = 8, CAL_W = 6 and TAP_W = 4. A second then lasts 256 + n enables, and one enable in every four is withheld. This allows whole seconds at the largest calibration value of 63 to be measured many times over. Spreading the enables out with idle gaps shows that only enabled cycles count. At the largest calibration value, the half-second point shows whether withheld enables fall in the correct positions, because the removals then continue past the middle of the second.

// File: rtl/cal_prescaler_pkg.sv
package cal_prescaler_pkg;

  // How the current cycle's enable is treated
  typedef enum logic [1:0] {
    PULSE_IDLE    = 2'd0,
    PULSE_COUNT   = 2'd1,
    PULSE_SWALLOW = 2'd2
  } pulse_kind_e;

  // True when the lowest nbits of v are all ones
  function automatic logic low_bits_set(input logic [31:0] v, input int unsigned nbits);
    logic [31:0] mask;
    mask = (32'd1 << nbits) - 32'd1;
    return (v & mask) == mask;
  endfunction

endpackage

// File: rtl/cps_swallow_ctl.sv
module cps_swallow_ctl
  import cal_prescaler_pkg::*;
#(
  parameter int CAL_W    = 6,
  parameter int GAP_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_en_i,
  input  logic [CAL_W-1:0]  cal_n_i,
  input  logic              wrap_i,
  output pulse_kind_e       kind_o,
  output logic [CAL_W-1:0]  n_lat_o,
  output logic [CAL_W-1:0]  sw_cnt_o
);

  localparam logic [CAL_W-1:0]    SW_ONE  = CAL_W'(1);
  localparam logic [GAP_BITS-1:0] GAP_ONE = GAP_BITS'(1);

  logic [GAP_BITS-1:0] gap_q;
  logic [CAL_W-1:0]    sw_q;
  logic [CAL_W-1:0]    n_q;
  logic                pending;
  logic                gap_full;

  // sw_q never exceeds n_q, so inequality means removals remain (R3)
  assign pending  = (sw_q != n_q);
  assign gap_full = &gap_q;

  always_comb begin
    if (!pulse_en_i)             kind_o = PULSE_IDLE;
    else if (pending && gap_full) kind_o = PULSE_SWALLOW;   // R4 spacing
    else                          kind_o = PULSE_COUNT;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gap_q <= '0;
      sw_q  <= '0;
      n_q   <= cal_n_i;                 // R8 sample under reset
    end else if (wrap_i) begin
      gap_q <= '0;
      sw_q  <= '0;
      n_q   <= cal_n_i;                 // R8 sample at the boundary
    end else if (kind_o == PULSE_SWALLOW) begin
      gap_q <= '0;
      sw_q  <= sw_q + SW_ONE;
    end else if (kind_o == PULSE_COUNT && pending) begin
      gap_q <= gap_q + GAP_ONE;
    end
  end

  assign n_lat_o  = n_q;
  assign sw_cnt_o = sw_q;

endmodule

// File: rtl/cps_divider.sv
module cps_divider
  import cal_prescaler_pkg::*;
#(
  parameter int DIV_BITS = 18,
  parameter int TAP_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              count_i,
  output logic              wrap_o,
  output logic              tick_o,
  output logic [TAP_W-1:0]  phase_o,
  output logic [TAP_W-1:0]  tap_stb_o
);

  localparam logic [DIV_BITS-1:0] DIV_ONE = DIV_BITS'(1);

  logic [DIV_BITS-1:0] div_q;
  logic [TAP_W-1:0]    stb_next;
  logic [TAP_W-1:0]    stb_q;
  logic                tick_q;

  assign wrap_o = count_i && (&div_q);

  // Strobe j fires when the low DIV_BITS-1-j bits roll over (R7)
  for (genvar j = 0; j < TAP_W; j++) begin : g_tap
    assign stb_next[j] = count_i && low_bits_set(32'(div_q), DIV_BITS - 1 - j);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tick_q <= 1'b0;
      stb_q  <= '0;
    end else begin
      if (count_i) div_q <= div_q + DIV_ONE;   // R1
      tick_q <= wrap_o;                         // R2
      stb_q  <= stb_next;
    end
  end

  assign tick_o    = tick_q;
  assign tap_stb_o = stb_q;
  assign phase_o   = div_q[DIV_BITS-1 -: TAP_W];  // R6

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cal_prescaler_pkg::*;
#(
  parameter int DIV_BITS = 18,
  parameter int CAL_W    = 6,
  parameter int TAP_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_en_i,
  input  logic [CAL_W-1:0]  cal_n_i,
  output logic              tick_1hz_o,
  output logic [TAP_W-1:0]  phase_o,
  output logic [TAP_W-1:0]  tap_stb_o
);

  // Spacing of withheld enables: all removals end before the second does
  localparam int GAP_BITS = DIV_BITS - CAL_W;

  pulse_kind_e      kind;
  logic [CAL_W-1:0] n_lat;
  logic [CAL_W-1:0] sw_cnt;
  logic             wrap;
  logic             count_en;

  assign count_en = (kind == PULSE_COUNT);

  cps_swallow_ctl #(
    .CAL_W    (CAL_W),
    .GAP_BITS (GAP_BITS)
  ) u_swallow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_en_i (pulse_en_i),
    .cal_n_i    (cal_n_i),
    .wrap_i     (wrap),
    .kind_o     (kind),
    .n_lat_o    (n_lat),
    .sw_cnt_o   (sw_cnt)
  );

  cps_divider #(
    .DIV_BITS (DIV_BITS),
    .TAP_W    (TAP_W)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count_en),
    .wrap_o    (wrap),
    .tick_o    (tick_1hz_o),
    .phase_o   (phase_o),
    .tap_stb_o (tap_stb_o)
  );

endmodule

// File: rtl/cal_prescaler_chk.sv
module cal_prescaler_chk
  import cal_prescaler_pkg::*;
#(
  parameter int CAL_W = 6,
  parameter int TAP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pulse_en_i,
  input logic              tick_1hz_o,
  input logic [TAP_W-1:0]  phase_o,
  input pulse_kind_e       kind,
  input logic [CAL_W-1:0]  n_lat,
  input logic [CAL_W-1:0]  sw_cnt,
  input logic              wrap
);

  AST_SWALLOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_cnt <= n_lat);                                                   // R3

  AST_SECOND_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |-> sw_cnt == n_lat);                                          // R3

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_o |=> !tick_1hz_o);                                        // R2

  AST_TICK_PHASE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_o |-> phase_o == '0);                                      // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_en_i |=> $stable(phase_o) && !tick_1hz_o);                   // R5

  AST_SWALLOW_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind == PULSE_SWALLOW |=> $stable(phase_o) && !tick_1hz_o);         // R4

  AST_CAL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(n_lat));                                          // R8

endmodule

bind cal_prescaler cal_prescaler_chk #(
  .CAL_W (CAL_W),
  .TAP_W (TAP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pulse_en_i (pulse_en_i),
  .tick_1hz_o (tick_1hz_o),
  .phase_o    (phase_o),
  .kind       (kind),
  .n_lat      (n_lat),
  .sw_cnt     (sw_cnt),
  .wrap       (wrap)
);

// File: tb/cal_prescaler_bench.sv
`timescale 1ns/1ps
module cal_prescaler_bench;

  localparam int DIV_BITS = 8;
  localparam int CAL_W    = 6;
  localparam int TAP_W    = 4;
  localparam int GAP_B    = DIV_BITS - CAL_W;
  localparam int SEC      = 1 << DIV_BITS;

  // {cal, idle gap between enables}
  localparam logic [15:0] VEC [6] = '{16'h0000, 16'h0100, 16'h3F00,
                                      16'h0502, 16'h2001, 16'h1103};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse_en = 1'b0;
  logic [CAL_W-1:0] cal = '0;
  logic             tick;
  logic [TAP_W-1:0] phase;
  logic [TAP_W-1:0] tap_stb;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cal_prescaler #(.DIV_BITS(DIV_BITS), .CAL_W(CAL_W), .TAP_W(TAP_W)) u_cal_prescaler (
    .clk_i(clk), .rst_ni(rst_n), .pulse_en_i(pulse_en), .cal_n_i(cal),
    .tick_1hz_o(tick), .phase_o(phase), .tap_stb_o(tap_stb)
  );

  // Enable generator
  bit run_en = 0;
  int gap_cfg = 0, idle_left = 0;
  always begin
    @(posedge clk); #1;
    if (run_en && idle_left == 0) begin pulse_en = 1'b1; idle_left = gap_cfg; end
    else begin pulse_en = 1'b0; if (idle_left > 0) idle_left--; end
  end

  // Monitor, sampled mid-cycle
  int cnt, last_period, half_at, msb_hi, last_msb_hi, seconds = 0;
  int phase_bad, run_bad;
  int stb_cnt [TAP_W];
  int last_stb [TAP_W];
  bit prev_msb, tick_prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0; last_period = 0; half_at = 0; msb_hi = 0; last_msb_hi = 0;
      prev_msb = 0; tick_prev = 0;
      for (int j = 0; j < TAP_W; j++) begin stb_cnt[j] = 0; last_stb[j] = 0; end
    end else begin
      for (int j = 0; j < TAP_W; j++) if (tap_stb[j]) stb_cnt[j]++;
      if (phase[TAP_W-1]) msb_hi++;
      if (tick) begin
        if (phase != '0) phase_bad++;
        if (tick_prev) run_bad++;
        last_period = cnt; cnt = 0;
        last_msb_hi = msb_hi; msb_hi = 0;
        for (int j = 0; j < TAP_W; j++) begin last_stb[j] = stb_cnt[j]; stb_cnt[j] = 0; end
        seconds++;
      end
      if (phase[TAP_W-1] && !prev_msb) half_at = cnt;
      prev_msb = phase[TAP_W-1];
      tick_prev = tick;
      if (pulse_en) cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_sec(input int k);
    int target;
    target = seconds + k;
    while (seconds < target) begin @(negedge clk); #1; end
  endtask

  function automatic int half_expect(input int n);
    for (int r = 1; r < 4 * SEC; r++) begin
      int rm;
      rm = (r >> GAP_B) < n ? (r >> GAP_B) : n;
      if (r - rm == SEC / 2) return r;
    end
    return -1;
  endfunction

  task automatic check_second(input int n, input string tag);
    chk(last_period == SEC + n, {tag, " R3 period"}, last_period, SEC + n);
    chk(half_at == half_expect(n), {tag, " R4 half point"}, half_at, half_expect(n));
    for (int j = 0; j < TAP_W; j++)
      chk(last_stb[j] == (2 << j), {tag, " R7 strobe count"}, last_stb[j], 2 << j);
  endtask

  initial begin
    int ph;
    int sec0;
    phase_bad = 0; run_bad = 0;
    cal = 6'd3;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tick == 1'b0, "R9 tick in reset", tick, 0);
    chk(phase == '0, "R9 phase in reset", phase, 0);
    chk(tap_stb == '0, "R9 strobes in reset", tap_stb, 0);
    @(posedge clk); #1;
    rst_n = 1'b1; run_en = 1; gap_cfg = 0;

    // First second uses the value sampled in reset
    wait_sec(1);
    check_second(3, "R8 first second");

    // Table of calibration values and enable spacings
    for (int i = 0; i < 6; i++) begin
      cal = VEC[i][13:8];
      gap_cfg = int'(VEC[i][7:0]);
      wait_sec(1);
      wait_sec(1);
      check_second(int'(VEC[i][13:8]), $sformatf("R1 vec%0d", i));
      if (VEC[i][13:8] == 6'd0 && VEC[i][7:0] == 8'd0)
        chk(last_msb_hi == SEC / 2, "R6 colon duty", last_msb_hi, SEC / 2);
    end

    // Idle cycles: nothing moves
    gap_cfg = 0;
    repeat (30) @(posedge clk);
    run_en = 0;
    repeat (3) @(negedge clk);
    ph = int'(phase); sec0 = seconds;
    repeat (40) @(negedge clk);
    chk(int'(phase) == ph, "R5 phase held while idle", int'(phase), ph);
    chk(seconds == sec0, "R5 no tick while idle", seconds, sec0);
    run_en = 1;

    // Mid-second change applies to the next second
    cal = 6'd10;
    wait_sec(1);
    repeat (20) @(posedge clk);
    cal = 6'd50;
    wait_sec(1);
    chk(last_period == SEC + 10, "R8 old value kept", last_period, SEC + 10);
    wait_sec(1);
    chk(last_period == SEC + 50, "R8 new value used", last_period, SEC + 50);

    // Reset in the middle of a second
    repeat (77) @(posedge clk);
    #1; rst_n = 1'b0; cal = 6'd7;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    wait_sec(1);
    chk(last_period == SEC + 7, "R9 full second after reset", last_period, SEC + 7);

    chk(run_bad == 0, "R2 tick width", run_bad, 0);
    chk(phase_bad == 0, "R6 phase zero at tick", phase_bad, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule